// File: doc/BRIEF.md
# Halt Wake-Up and Reset-Cause Controller

This block sequences the power-down state of a small 8-bit microcontroller core. When the instruction decoder signals a halt, the controller drops the system clock enable, asks for the watchdog count to be cleared, and records the halt in a power-down flag. While halted it watches for three wake sources: a watchdog overflow, a newly raised interrupt request, and a high-to-low edge on any enabled bit of the wake port. An active-low external reset pin overrides everything.

Once a wake source is seen, a settling window of a fixed number of clock cycles runs while the core stays stopped. At the end of the window a single-cycle pulse tells the core what to do. The choices are: continue with the next instruction, enter the service routine of a given interrupt, or perform a warm reset that restores only the program counter and stack pointer. A watchdog overflow during normal running instead produces an immediate full core reset. Two status flags, power-down and time-out, let software work out why it restarted.

Top module: `halt_wake_ctrl`

## Requirements
- R1: While `rst_n` is low, `core_rst` is 1. Two clock edges after `rst_n` rises, `core_rst` is 0, `clk_en` is 1, both flags are 0 and no action pulse is active.
- R2: A `halt_req` pulse while running, with no `wdt_ovf` in that cycle, gives the following in the next cycle: `clk_en` is 0, `pwrdn_flag` is 1, `tmo_flag` is 0, and `wdt_clr` pulses for one cycle.
- R3: A `clrwdt_req` pulse while running, with no halt or overflow in that cycle, clears `pwrdn_flag` in the next cycle and pulses `wdt_clr`.
- R4: While halted, a high-to-low transition on a bit of `port_in` whose `port_wake_en` bit is 1 wakes the block, which then ends with a `resume_next` pulse. A falling edge on a disabled bit does not wake it. A bit already low at halt entry does not wake it either.
- R5: The action pulse comes exactly SETTLE_CYC cycles after the cycle in which the wake is decided. `clk_en` stays 0 until the pulse cycle and is 1 in that cycle. `port_in` passes through a two-stage synchronizer, which adds two cycles before the decision.
- R6: An interrupt wake whose interrupt is enabled in `irq_en` with `stack_full` at 0 ends with a `take_irq` pulse, with `irq_vec` set to the index of that request. If several new requests rise together, the lowest index wins.
- R7: An interrupt wake ends with `resume_next` and no `take_irq` if that interrupt's `irq_en` bit is 0, or if `stack_full` is 1 when the window ends.
- R8: An `irq_req` bit that was already 1 in the cycle the halt was accepted cannot wake the block during that halt.
- R9: A `wdt_ovf` while halted sets `tmo_flag` and ends with a `warm_rst` pulse. `pwrdn_flag` stays 1.
- R10: A `wdt_ovf` while running pulses `core_rst` in the next cycle and sets `tmo_flag`. `clk_en` stays 1.
- R11: When wake sources are decided in the same cycle, the watchdog overflow wins over an interrupt, and an interrupt wins over a port edge.
- R12: During the settling window, further overflows, halt requests, port edges and interrupts are ignored. The pending action and the flags are unchanged.
- R13: Pulling `rst_n` low while halted returns the block to running with both flags at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running controller clock |
| rst_n | input | 1 | External reset, active low, asynchronous assert |
| halt_req | input | 1 | Halt instruction executed (one-cycle pulse) |
| clrwdt_req | input | 1 | Clear-watchdog instruction executed (one-cycle pulse) |
| wdt_ovf | input | 1 | Watchdog overflow (one-cycle pulse) |
| irq_req | input | IRQ_N | Interrupt request flags |
| irq_en | input | IRQ_N | Per-interrupt enables |
| stack_full | input | 1 | Return stack has no free entry |
| port_in | input | PORT_W | Wake port pins, asynchronous |
| port_wake_en | input | PORT_W | Per-bit wake enable |
| clk_en | output | 1 | System clock enable for the core |
| wdt_clr | output | 1 | Clear-and-restart request to the watchdog |
| resume_next | output | 1 | Pulse: continue at the next instruction |
| take_irq | output | 1 | Pulse: enter the interrupt in irq_vec |
| irq_vec | output | IRQ_IW | Index of the interrupt to service |
| warm_rst | output | 1 | Pulse: restore program counter and stack pointer only |
| core_rst | output | 1 | Full core reset |
| pwrdn_flag | output | 1 | Power-down status flag |
| tmo_flag | output | 1 | Watchdog time-out status flag |

## Verification
A watchdog overflow and an interrupt request can be decided in the same halted cycle. So can an interrupt and a port edge. The bench lowers the port bit two cycles before raising the other sources, because the synchronizer delays the port edge by that much, so all of them reach the decision logic together. The result is judged by which pulse ends the window: `warm_rst` when the overflow is present, `take_irq` when only the interrupt and the port edge meet. The bench also checks the time-out flag. A second case sends overflows, halts, port edges and interrupts into an open settling window, and requires that the original action still arrives and that the flags stay as they were.

// File: rtl/hwk_pkg.sv
package hwk_pkg;
    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_HALT   = 2'd1,
        ST_SETTLE = 2'd2
    } hwk_state_e;

    typedef enum logic [1:0] {
        WK_NONE = 2'd0,
        WK_PORT = 2'd1,
        WK_IRQ  = 2'd2,
        WK_WDT  = 2'd3
    } hwk_reason_e;
endpackage

// File: rtl/hwk_rst_sync.sv
module hwk_rst_sync (
    input  logic clk,
    input  logic rst_n,
    output logic rst_ok
);
    logic [1:0] stage_q;
    logic [1:0] stage_d;

    always_comb begin
        stage_d = {stage_q[0], 1'b1};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= 2'b00;
        else        stage_q <= stage_d;
    end

    assign rst_ok = stage_q[1];
endmodule

// File: rtl/hwk_sync2.sv
module hwk_sync2 #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] s1_q, s2_q;
    logic [W-1:0] s1_d, s2_d;

    always_comb begin
        s1_d = din;
        s2_d = s1_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= s1_d;
            s2_q <= s2_d;
        end
    end

    assign dout = s2_q;
endmodule

// File: rtl/hwk_settle_cnt.sv
module hwk_settle_cnt #(
    parameter int CYC = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int CW = (CYC > 1) ? $clog2(CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(CYC - 1);

    logic [CW-1:0] cnt_q, cnt_d;

    assign done = run && (cnt_q == LAST);

    always_comb begin
        if (!run)      cnt_d = '0;
        else if (done) cnt_d = '0;
        else           cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/hwk_wake_detect.sv
module hwk_wake_detect #(
    parameter int PORT_W = 8,
    parameter int IRQ_N  = 4,
    parameter int IRQ_IW = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              armed,
    input  logic [PORT_W-1:0] port_in,
    input  logic [PORT_W-1:0] port_en,
    input  logic [IRQ_N-1:0]  irq_req,
    input  logic [IRQ_N-1:0]  irq_mask,
    output logic              wake_port,
    output logic              wake_irq,
    output logic [IRQ_IW-1:0] irq_idx
);
    logic [PORT_W-1:0] pin_s;
    logic [PORT_W-1:0] prev_q, prev_d;
    logic [PORT_W-1:0] falls;
    logic [IRQ_N-1:0]  fresh;

    hwk_sync2 #(.W(PORT_W)) u_psync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (port_in),
        .dout (pin_s)
    );

    always_comb begin
        prev_d = pin_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    always_comb begin
        falls     = prev_q & ~pin_s & port_en;
        fresh     = irq_req & ~irq_mask;
        wake_port = armed && (|falls);
        wake_irq  = armed && (|fresh);
        irq_idx   = '0;
        for (int i = IRQ_N - 1; i >= 0; i--) begin
            if (fresh[i]) irq_idx = IRQ_IW'(i);
        end
    end
endmodule

// File: rtl/halt_wake_ctrl.sv
module halt_wake_ctrl
    import hwk_pkg::*;
#(
    parameter int PORT_W     = 8,
    parameter int IRQ_N      = 4,
    parameter int SETTLE_CYC = 1024,
    localparam int IRQ_IW    = (IRQ_N > 1) ? $clog2(IRQ_N) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              halt_req,
    input  logic              clrwdt_req,
    input  logic              wdt_ovf,
    input  logic [IRQ_N-1:0]  irq_req,
    input  logic [IRQ_N-1:0]  irq_en,
    input  logic              stack_full,
    input  logic [PORT_W-1:0] port_in,
    input  logic [PORT_W-1:0] port_wake_en,
    output logic              clk_en,
    output logic              wdt_clr,
    output logic              resume_next,
    output logic              take_irq,
    output logic [IRQ_IW-1:0] irq_vec,
    output logic              warm_rst,
    output logic              core_rst,
    output logic              pwrdn_flag,
    output logic              tmo_flag
);
    typedef struct packed {
        hwk_state_e        state;
        logic              pwrdn;
        logic              tmo;
        hwk_reason_e       why;
        logic [IRQ_IW-1:0] vec;
        logic [IRQ_N-1:0]  mask;
        logic              act_next;
        logic              act_irq;
        logic              act_warm;
        logic              act_full;
        logic              wclr;
    } ctl_t;

    localparam ctl_t CTL_RST = '{
        state: ST_RUN, pwrdn: 1'b0, tmo: 1'b0, why: WK_NONE,
        vec: '0, mask: '0, act_next: 1'b0, act_irq: 1'b0,
        act_warm: 1'b0, act_full: 1'b0, wclr: 1'b0
    };

    logic              rst_ok;
    logic              wake_port, wake_irq, settle_done;
    logic [IRQ_IW-1:0] irq_idx;
    ctl_t              ctl_q, ctl_d;

    hwk_rst_sync u_rsync (
        .clk   (clk),
        .rst_n (rst_n),
        .rst_ok(rst_ok)
    );

    hwk_wake_detect #(
        .PORT_W(PORT_W),
        .IRQ_N (IRQ_N),
        .IRQ_IW(IRQ_IW)
    ) u_wake (
        .clk      (clk),
        .rst_n    (rst_ok),
        .armed    (ctl_q.state == ST_HALT),
        .port_in  (port_in),
        .port_en  (port_wake_en),
        .irq_req  (irq_req),
        .irq_mask (ctl_q.mask),
        .wake_port(wake_port),
        .wake_irq (wake_irq),
        .irq_idx  (irq_idx)
    );

    hwk_settle_cnt #(.CYC(SETTLE_CYC)) u_settle (
        .clk  (clk),
        .rst_n(rst_ok),
        .run  (ctl_q.state == ST_SETTLE),
        .done (settle_done)
    );

    always_comb begin
        ctl_d          = ctl_q;
        ctl_d.act_next = 1'b0;
        ctl_d.act_irq  = 1'b0;
        ctl_d.act_warm = 1'b0;
        ctl_d.act_full = 1'b0;
        ctl_d.wclr     = 1'b0;
        unique case (ctl_q.state)
            ST_RUN: begin
                if (wdt_ovf) begin
                    ctl_d.tmo      = 1'b1;
                    ctl_d.act_full = 1'b1;
                end else if (halt_req) begin
                    ctl_d.state = ST_HALT;
                    ctl_d.pwrdn = 1'b1;
                    ctl_d.tmo   = 1'b0;
                    ctl_d.wclr  = 1'b1;
                    ctl_d.mask  = irq_req;
                end else if (clrwdt_req) begin
                    ctl_d.pwrdn = 1'b0;
                    ctl_d.wclr  = 1'b1;
                end
            end
            ST_HALT: begin
                if (wdt_ovf) begin
                    ctl_d.state = ST_SETTLE;
                    ctl_d.why   = WK_WDT;
                    ctl_d.tmo   = 1'b1;
                end else if (wake_irq) begin
                    ctl_d.state = ST_SETTLE;
                    ctl_d.why   = WK_IRQ;
                    ctl_d.vec   = irq_idx;
                end else if (wake_port) begin
                    ctl_d.state = ST_SETTLE;
                    ctl_d.why   = WK_PORT;
                end
            end
            ST_SETTLE: begin
                if (settle_done) begin
                    ctl_d.state = ST_RUN;
                    ctl_d.why   = WK_NONE;
                    case (ctl_q.why)
                        WK_WDT: ctl_d.act_warm = 1'b1;
                        WK_IRQ: begin
                            if (irq_en[ctl_q.vec] && !stack_full) ctl_d.act_irq  = 1'b1;
                            else                                  ctl_d.act_next = 1'b1;
                        end
                        default: ctl_d.act_next = 1'b1;
                    endcase
                end
            end
            default: ctl_d = CTL_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_ok) begin
        if (!rst_ok) ctl_q <= CTL_RST;
        else         ctl_q <= ctl_d;
    end

    assign clk_en      = (ctl_q.state == ST_RUN);
    assign wdt_clr     = ctl_q.wclr;
    assign resume_next = ctl_q.act_next;
    assign take_irq    = ctl_q.act_irq;
    assign irq_vec     = ctl_q.vec;
    assign warm_rst    = ctl_q.act_warm;
    assign core_rst    = !rst_ok || ctl_q.act_full;
    assign pwrdn_flag  = ctl_q.pwrdn;
    assign tmo_flag    = ctl_q.tmo;
endmodule

// File: rtl/hwk_checker.sv
module hwk_checker (
    input logic clk,
    input logic rst_ok,
    input logic halt_req,
    input logic clrwdt_req,
    input logic wdt_ovf,
    input logic stack_full,
    input logic clk_en,
    input logic resume_next,
    input logic take_irq,
    input logic warm_rst,
    input logic core_rst,
    input logic pwrdn_flag,
    input logic tmo_flag
);
    a_r2_halt_entry: assert property (@(posedge clk) disable iff (!rst_ok)
        clk_en && halt_req && !wdt_ovf |=> !clk_en && pwrdn_flag && !tmo_flag);

    a_r3_clear_pwrdn: assert property (@(posedge clk) disable iff (!rst_ok)
        clk_en && clrwdt_req && !halt_req && !wdt_ovf |=> !pwrdn_flag);

    a_r5_act_ends_gap: assert property (@(posedge clk) disable iff (!rst_ok)
        (resume_next || take_irq || warm_rst) |-> clk_en && $past(!clk_en));

    a_r5_no_silent_restart: assert property (@(posedge clk) disable iff (!rst_ok)
        $rose(clk_en) |-> (resume_next || take_irq || warm_rst));

    a_r7_irq_needs_stack: assert property (@(posedge clk) disable iff (!rst_ok)
        take_irq |-> $past(!stack_full));

    a_r9_warm_flags: assert property (@(posedge clk) disable iff (!rst_ok)
        warm_rst |-> tmo_flag && pwrdn_flag);

    a_r10_run_overflow: assert property (@(posedge clk) disable iff (!rst_ok)
        clk_en && wdt_ovf |=> core_rst && tmo_flag && clk_en);

    a_r11_one_action: assert property (@(posedge clk) disable iff (!rst_ok)
        $onehot0({resume_next, take_irq, warm_rst, core_rst}));
endmodule

bind halt_wake_ctrl hwk_checker u_chk (
    .clk        (clk),
    .rst_ok     (rst_ok),
    .halt_req   (halt_req),
    .clrwdt_req (clrwdt_req),
    .wdt_ovf    (wdt_ovf),
    .stack_full (stack_full),
    .clk_en     (clk_en),
    .resume_next(resume_next),
    .take_irq   (take_irq),
    .warm_rst   (warm_rst),
    .core_rst   (core_rst),
    .pwrdn_flag (pwrdn_flag),
    .tmo_flag   (tmo_flag)
);

// File: tb/sim_halt_wake_ctrl.sv
`timescale 1ns/1ps
module sim_halt_wake_ctrl;
    localparam int NSET  = 1024;
    localparam int LIMIT = NSET + 50;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       halt_req = 1'b0, clrwdt_req = 1'b0, wdt_ovf = 1'b0, stack_full = 1'b0;
    logic [3:0] irq_req = '0, irq_en = 4'hF;
    logic [7:0] port_in = 8'hFF, port_wake_en = '0;
    logic       clk_en, wdt_clr, resume_next, take_irq, warm_rst, core_rst, pwrdn_flag, tmo_flag;
    logic [1:0] irq_vec;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    halt_wake_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .clrwdt_req(clrwdt_req),
        .wdt_ovf(wdt_ovf), .irq_req(irq_req), .irq_en(irq_en), .stack_full(stack_full),
        .port_in(port_in), .port_wake_en(port_wake_en), .clk_en(clk_en), .wdt_clr(wdt_clr),
        .resume_next(resume_next), .take_irq(take_irq), .irq_vec(irq_vec),
        .warm_rst(warm_rst), .core_rst(core_rst), .pwrdn_flag(pwrdn_flag), .tmo_flag(tmo_flag)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input string what, input int act, input int exp);
        chk(act == exp, req, what, act, exp);
    endtask

    task automatic do_halt();
        halt_req = 1'b1;
        @(negedge clk);
        halt_req = 1'b0;
    endtask

    // counts negedges since the stimulus cycle until an action pulse shows
    task automatic wait_act(output int n, output bit gated);
        n = 1;
        gated = 1'b1;
        while (!(resume_next || take_irq || warm_rst) && n < LIMIT) begin
            if (clk_en) gated = 1'b0;
            @(negedge clk);
            n++;
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk_eq("R1", "core_rst in reset", core_rst, 1);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk_eq("R1", "core_rst", core_rst, 0);
        chk_eq("R1", "clk_en", clk_en, 1);
        chk_eq("R1", "flags", {pwrdn_flag, tmo_flag}, 0);
        chk_eq("R1", "pulses", {resume_next, take_irq, warm_rst, wdt_clr}, 0);
    endtask

    task automatic t_halt_entry();
        int n; bit g;
        port_wake_en = 8'h01;
        @(negedge clk);
        do_halt();
        chk_eq("R2", "clk_en", clk_en, 0);
        chk_eq("R2", "pwrdn", pwrdn_flag, 1);
        chk_eq("R2", "tmo", tmo_flag, 0);
        chk_eq("R2", "wdt_clr", wdt_clr, 1);
        @(negedge clk);
        chk_eq("R2", "wdt_clr width", wdt_clr, 0);
        port_in = 8'hFE;
        @(negedge clk);
        wait_act(n, g);
        chk_eq("R5", "port wake latency", n, NSET + 3);
        chk_eq("R5", "clk gated in window", g, 1);
        chk_eq("R4", "resume_next", resume_next, 1);
        port_in = 8'hFF;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_clrwdt();
        chk_eq("R3", "pwrdn before", pwrdn_flag, 1);
        clrwdt_req = 1'b1;
        @(negedge clk);
        clrwdt_req = 1'b0;
        chk_eq("R3", "pwrdn after", pwrdn_flag, 0);
        chk_eq("R3", "wdt_clr", wdt_clr, 1);
    endtask

    task automatic t_port();
        int n; bit g;
        port_wake_en = 8'h21;
        port_in = 8'hFE;
        repeat (4) @(negedge clk);
        do_halt();
        repeat (20) @(negedge clk);
        chk_eq("R4", "low level at entry no wake", clk_en, 0);
        port_in = 8'hF6;
        repeat (20) @(negedge clk);
        chk_eq("R4", "disabled bit no wake", clk_en, 0);
        port_in = 8'hD6;
        @(negedge clk);
        wait_act(n, g);
        chk_eq("R4", "enabled bit wakes", n, NSET + 3);
        chk_eq("R4", "resume_next", resume_next, 1);
        chk_eq("R5", "clk_en in pulse cycle", clk_en, 1);
        port_in = 8'hFF;
        port_wake_en = '0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_irq_take();
        int n; bit g;
        irq_en = 4'hF;
        do_halt();
        irq_req = 4'b1010;
        @(negedge clk);
        wait_act(n, g);
        chk_eq("R6", "irq latency", n, NSET + 1);
        chk_eq("R6", "take_irq", take_irq, 1);
        chk_eq("R6", "lowest index wins", irq_vec, 1);
        irq_req = '0;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_irq_resume();
        int n; bit g;
        irq_en = 4'b1110;
        do_halt();
        irq_req = 4'b0001;
        @(negedge clk);
        wait_act(n, g);
        chk_eq("R7", "disabled irq resumes", {resume_next, take_irq}, 2);
        irq_req = '0;
        irq_en = 4'hF;
        @(negedge clk);
        do_halt();
        stack_full = 1'b1;
        irq_req = 4'b0100;
        @(negedge clk);
        wait_act(n, g);
        chk_eq("R7", "stack full resumes", {resume_next, take_irq}, 2);
        irq_req = '0;
        stack_full = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_irq_pending();
        int n; bit g;
        irq_req = 4'b0010;
        @(negedge clk);
        do_halt();
        repeat (30) @(negedge clk);
        chk_eq("R8", "pending irq no wake", clk_en, 0);
        irq_req = 4'b1010;
        @(negedge clk);
        wait_act(n, g);
        chk_eq("R8", "new irq wakes", take_irq, 1);
        chk_eq("R8", "vector of new irq", irq_vec, 3);
        irq_req = '0;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_wdt_halt();
        int n; bit g;
        do_halt();
        wdt_ovf = 1'b1;
        @(negedge clk);
        wdt_ovf = 1'b0;
        chk_eq("R9", "tmo set", tmo_flag, 1);
        wait_act(n, g);
        chk_eq("R9", "warm latency", n, NSET + 1);
        chk_eq("R9", "warm_rst", warm_rst, 1);
        chk_eq("R9", "pwrdn kept", pwrdn_flag, 1);
        chk_eq("R9", "core_rst low", core_rst, 0);
        @(negedge clk);
    endtask

    task automatic t_wdt_run();
        do_halt();
        @(negedge clk);
        chk_eq("R9", "halt clears tmo", tmo_flag, 0);
        irq_req = 4'b0001;
        @(negedge clk);
        while (!take_irq && clk_en == 0) @(negedge clk);
        irq_req = '0;
        @(negedge clk);
        wdt_ovf = 1'b1;
        @(negedge clk);
        wdt_ovf = 1'b0;
        chk_eq("R10", "core_rst pulse", core_rst, 1);
        chk_eq("R10", "tmo", tmo_flag, 1);
        chk_eq("R10", "clk_en", clk_en, 1);
        @(negedge clk);
        chk_eq("R10", "core_rst width", core_rst, 0);
    endtask

    task automatic t_priority();
        int n; bit g;
        port_wake_en = 8'h80;
        do_halt();
        port_in = 8'h7F;
        @(negedge clk);
        @(negedge clk);
        wdt_ovf = 1'b1;
        irq_req = 4'b0100;
        @(negedge clk);
        wdt_ovf = 1'b0;
        wait_act(n, g);
        chk_eq("R11", "wdt beats irq and port", {warm_rst, take_irq, resume_next}, 4);
        irq_req = '0;
        port_in = 8'hFF;
        repeat (4) @(negedge clk);
        do_halt();
        port_in = 8'h7F;
        @(negedge clk);
        @(negedge clk);
        irq_req = 4'b0100;
        @(negedge clk);
        wait_act(n, g);
        chk_eq("R11", "irq beats port", {warm_rst, take_irq, resume_next}, 2);
        chk_eq("R11", "vector", irq_vec, 2);
        chk_eq("R11", "tmo clear", tmo_flag, 0);
        irq_req = '0;
        port_in = 8'hFF;
        port_wake_en = '0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_settle_ignore();
        int n; bit g;
        port_wake_en = 8'hFF;
        do_halt();
        irq_req = 4'b0100;
        repeat (10) @(negedge clk);
        wdt_ovf = 1'b1;
        halt_req = 1'b1;
        irq_req = 4'b0101;
        port_in = 8'h00;
        @(negedge clk);
        wdt_ovf = 1'b0;
        halt_req = 1'b0;
        chk_eq("R12", "tmo unchanged", tmo_flag, 0);
        wait_act(n, g);
        chk_eq("R12", "original action kept", take_irq, 1);
        chk_eq("R12", "original vector", irq_vec, 2);
        repeat (2) @(negedge clk);
        chk_eq("R12", "halt in window ignored", clk_en, 1);
        chk_eq("R12", "tmo after", tmo_flag, 0);
        irq_req = '0;
        port_in = 8'hFF;
        port_wake_en = '0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_ext_reset();
        do_halt();
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk_eq("R13", "core_rst held", core_rst, 1);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk_eq("R13", "running", clk_en, 1);
        chk_eq("R13", "flags cleared", {pwrdn_flag, tmo_flag}, 0);
        chk_eq("R13", "core_rst released", core_rst, 0);
    endtask

    initial begin
        t_reset();
        t_halt_entry();
        t_clrwdt();
        t_port();
        t_irq_take();
        t_irq_resume();
        t_irq_pending();
        t_wdt_halt();
        t_wdt_run();
        t_priority();
        t_settle_ignore();
        t_ext_reset();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        failures++;
        checks++;
        $display("FAIL watchdog run did not finish actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule